// File: doc/BRIEF.md
# SPI Flash Boot Copier

This block moves a boot image out of a serial SPI flash into SRAM on its own, with no processor help. When reset is released and the `enable` level is high, it asserts flash chip select and sends a standard read request for flash address zero. It then keeps clocking the flash and assembles each incoming byte. Every completed byte goes to a simple synchronous SRAM write port.

The SRAM base address and the image length in bytes are fixed by parameters at elaboration time. The SPI clock runs in mode 0: it idles low, the block samples `spi_miso` on the rising edge and changes `spi_mosi` on the falling edge. Each clock phase lasts `HALF_DIV` system clock cycles. After the last byte, the block returns the SPI clock low and releases chip select. It then drops `busy` and raises `done`, which stays set until the next reset. The copy runs once more after every reset.

Top module: `boot_copier`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sclk` is 0, and `busy`, `done` and `sram_we` are 0.
- R2: While `enable` is low and no copy has started, the block stays idle. Chip select stays high, no SPI clock edges occur and no SRAM writes are made. The copy begins once `enable` is high.
- R3: The first 32 bits sent on `spi_mosi`, MSB first and sampled on rising `spi_sclk` edges, are the command byte 0x03 followed by a 24-bit address of zero.
- R4: Each high phase and each low phase of `spi_sclk` lasts exactly `HALF_DIV` system clock cycles.
- R5: Data byte k is built from the bits on `spi_miso`, MSB first, sampled on rising edges 33+8k to 40+8k. It is written once, with a one-cycle `sram_we` pulse, at address `BASE + k`.
- R6: A copy makes exactly `LEN` SRAM writes, and every write address lies in `BASE` to `BASE+LEN-1`.
- R7: `spi_cs_n` stays low from the start of the copy until after the last byte, and then returns high. `spi_sclk` is low whenever `spi_cs_n` is high.
- R8: `busy` is high for the whole copy. `done` is set when the copy ends and stays set, with no further SPI or SRAM activity, until reset. The two flags are never high together.
- R9: A reset during a copy aborts it. The next copy restarts with the read command and writes from `BASE` again.
- R10: Once a copy has started, dropping `enable` does not stop it. All `LEN` bytes are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Level that allows the copy to start |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| sram_we | output | 1 | One-cycle SRAM write strobe |
| sram_addr | output | AW | SRAM write address |
| sram_wdata | output | 8 | SRAM write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Copy finished, sticky until reset |

## Verification
Flash contents are tried as all zeros, as all ones, and as seeded random bytes. All zeros and all ones expose a stuck or inverted `spi_miso` path. Random bytes expose bit-order and byte-order faults. Before `enable` goes high, the bench waits a random number of cycles, which separates the level gate from any reliance on timing right after reset. Directed runs pulse reset in the middle of a copy and drop `enable` in the middle of a copy. Together these tell a restart-from-zero apart from a resumed copy, and a gate applied only at the start apart from one applied all the time.

// File: rtl/bootcopy_pkg.sv
package bootcopy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2,
    ST_DONE = 2'd3
  } bc_state_e;

  // read opcode followed by a zero 24-bit flash address
  function automatic logic [31:0] read_header(input logic [7:0] opcode);
    return {opcode, 24'h000000};
  endfunction

  // destination address of byte number idx
  function automatic logic [31:0] dest_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/bc_clkdiv.sv
module bc_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bc_txhdr.sv
module bc_txhdr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic         shift,
  output logic         mosi
);
  logic [W-1:0] sr;

  assign mosi = sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= value;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end
endmodule

// File: rtl/bc_rxbyte.sv
module bc_rxbyte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic       miso,
  output logic [7:0] byte_val,
  output logic       byte_done
);
  logic [6:0] sr;
  logic [2:0] bitn;

  assign byte_val  = {sr, miso};
  assign byte_done = sample && (bitn == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      bitn <= '0;
    end else if (clear) begin
      bitn <= '0;
    end else if (sample) begin
      sr   <= {sr[5:0], miso};
      bitn <= bitn + 3'd1;
    end
  end
endmodule

// File: rtl/boot_copier.sv
module boot_copier
  import bootcopy_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BASE     = 256,
  parameter int LEN      = 16,
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  output logic          busy,
  output logic          done
);
  localparam int HDR_BITS = 32;
  localparam int HCW      = $clog2(HDR_BITS + 1);
  localparam int IW       = $clog2(LEN + 1);

  bc_state_e     state;
  logic          sclk_q, cs_q, we_q;
  logic [HCW-1:0] hdr_cnt;
  logic [IW-1:0] byte_idx;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  // named internal events
  logic tick, run, start_ev, rise_ev, fall_ev, in_data, last_byte;
  logic byte_done;
  logic [7:0] byte_val;

  assign run       = (state == ST_XFER) || (state == ST_TAIL);
  assign start_ev  = (state == ST_IDLE) && enable;
  assign rise_ev   = tick && !sclk_q && (state == ST_XFER);
  assign fall_ev   = tick && sclk_q;
  assign in_data   = (hdr_cnt == HCW'(HDR_BITS));
  assign last_byte = byte_done && (byte_idx == IW'(LEN - 1));

  bc_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  bc_txhdr #(.W(HDR_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(start_ev), .value(read_header(8'h03)),
    .shift(fall_ev), .mosi(spi_mosi)
  );

  bc_rxbyte u_rx (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
    .sample(rise_ev && in_data), .miso(spi_miso),
    .byte_val(byte_val), .byte_done(byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      we_q     <= 1'b0;
      hdr_cnt  <= '0;
      byte_idx <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      we_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (enable) begin
            state    <= ST_XFER;
            cs_q     <= 1'b0;
            hdr_cnt  <= '0;
            byte_idx <= '0;
          end
        end
        ST_XFER: begin
          if (tick) sclk_q <= ~sclk_q;
          if (rise_ev && !in_data) hdr_cnt <= hdr_cnt + 1'b1;
          if (byte_done) begin
            we_q     <= 1'b1;
            addr_q   <= AW'(dest_addr(32'(BASE), 32'(byte_idx)));
            data_q   <= byte_val;
            byte_idx <= byte_idx + 1'b1;
            if (last_byte) state <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
            state  <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign spi_sclk   = sclk_q;
  assign spi_cs_n   = cs_q;
  assign sram_we    = we_q;
  assign sram_addr  = addr_q;
  assign sram_wdata = data_q;
  assign busy       = run;
  assign done       = (state == ST_DONE);
endmodule

// File: rtl/boot_copier_chk.sv
module boot_copier_chk #(
  parameter int AW   = 16,
  parameter int BASE = 256,
  parameter int LEN  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          spi_sclk,
  input logic          spi_cs_n,
  input logic          sram_we,
  input logic [AW-1:0] sram_addr,
  input logic          busy,
  input logic          done
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(enable)); // R2
  AST_CLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R7
  AST_CLK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> busy); // R7
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !sram_we); // R5
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (32'(sram_addr) >= 32'(BASE)) && (32'(sram_addr) < 32'(BASE + LEN))); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n && !sram_we); // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
endmodule

bind boot_copier boot_copier_chk #(.AW(AW), .BASE(BASE), .LEN(LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .sram_we(sram_we), .sram_addr(sram_addr),
  .busy(busy), .done(done)
);

// File: tb/boot_copier_test.sv
`timescale 1ns/1ps
module boot_copier_test;
  localparam int AW = 16, BASE = 256, LEN = 16, HALF_DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi, sram_we, busy, done;
  logic spi_miso = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [7:0] sram_wdata;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  boot_copier #(.AW(AW), .BASE(BASE), .LEN(LEN), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .busy(busy), .done(done)
  );

  // flash model, mode 0
  logic [7:0] fmem [LEN];
  logic [31:0] cmd_sh = 0, cmd_last = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  int rcnt = 0, fcnt = 0;
  time t_f5 = 0, t_r6 = 0;

  always @(spi_sclk or spi_cs_n) begin
    if (spi_cs_n !== 1'b0) begin
      rcnt = 0; fcnt = 0; prev_sclk = 1'b0;
    end else begin
      if (prev_cs) cmd_last = 32'h0;
      if (spi_sclk && !prev_sclk) begin
        rcnt++;
        if (rcnt <= 32) begin
          cmd_sh = {cmd_sh[30:0], spi_mosi};
          if (rcnt == 32) cmd_last = cmd_sh;
        end
        if (rcnt == 6) t_r6 = $time;
      end else if (!spi_sclk && prev_sclk) begin
        fcnt++;
        if (fcnt == 5) t_f5 = $time;
        if (fcnt >= 32) begin
          int bi;
          bi = fcnt - 32;
          spi_miso = fmem[(bi / 8) % LEN][7 - (bi % 8)];
        end
      end
      prev_sclk = spi_sclk;
    end
    prev_cs = (spi_cs_n !== 1'b0);
  end

  // SRAM write log
  logic [AW-1:0] wa [1024];
  logic [7:0]    wd [1024];
  int wr_total = 0;
  always @(negedge clk) begin
    if (rst_n && sram_we === 1'b1) begin
      wa[wr_total % 1024] = sram_addr;
      wd[wr_total % 1024] = sram_wdata;
      wr_total++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_header();
    logic [31:0] h;
    h = 32'h0;
    h[31:24] = 8'b0000_0011;
    return h;
  endfunction

  task automatic fill(input int kind);
    for (int k = 0; k < LEN; k++) begin
      if (kind == 0)      fmem[k] = 8'h00;
      else if (kind == 1) fmem[k] = 8'hFF;
      else                fmem[k] = 8'($urandom);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic verify(input string tag, input int base_cnt);
    logic [31:0] ea;
    check(cmd_last == exp_header(), {"R3 header ", tag}, cmd_last, exp_header());
    check(wr_total - base_cnt == LEN, {"R6 write count ", tag}, wr_total - base_cnt, LEN);
    ea = BASE;
    for (int k = 0; k < LEN; k++) begin
      check(32'(wa[(base_cnt + k) % 1024]) == ea, {"R5 addr ", tag}, 32'(wa[(base_cnt + k) % 1024]), ea);
      check(wd[(base_cnt + k) % 1024] == fmem[k], {"R5 data ", tag}, 32'(wd[(base_cnt + k) % 1024]), 32'(fmem[k]));
      ea = ea + 1;
    end
    check((t_r6 - t_f5) == HALF_DIV * 10, {"R4 half period ", tag}, 32'(t_r6 - t_f5), HALF_DIV * 10);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, {"R7 released ", tag}, {spi_cs_n, spi_sclk}, 2'b10);
    check(done == 1'b1 && busy == 1'b0, {"R8 flags ", tag}, {done, busy}, 2'b10);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_copy(input string tag);
    int b;
    b = wr_total;
    enable = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b1 && spi_cs_n == 1'b0, {"R8 busy during copy ", tag}, {busy, spi_cs_n}, 2'b10);
    wait_done();
    verify(tag, b);
  endtask

  initial begin
    int b;
    void'($urandom(32'hB007_C0DE));
    // reset state R1
    rst_n = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0 && sram_we == 0,
          "R1 reset outputs", {spi_cs_n, spi_sclk, busy, done, sram_we}, 5'b10000);
    // enable low keeps idle: R2
    fill(2);
    rst_n = 1'b1;
    repeat (150) @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0 && busy == 0 && done == 0 && wr_total == 0,
          "R2 idle while disabled", {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
    run_copy("first");
    // done sticky R8
    b = wr_total;
    repeat (100) @(negedge clk);
    check(done == 1 && spi_cs_n == 1 && wr_total == b, "R8 done sticky", {done, spi_cs_n}, 2'b11);

    // pattern and random runs
    for (int r = 0; r < 6; r++) begin
      enable = 1'b0;
      fill(r < 2 ? r : 2);
      do_reset();
      repeat ($urandom_range(0, 20)) @(negedge clk);
      check(spi_cs_n == 1 && wr_total == b, "R2 waits for enable", {31'd0, spi_cs_n}, 1);
      run_copy($sformatf("run%0d", r));
      b = wr_total;
    end

    // reset mid copy: R9
    enable = 1'b0;
    fill(2);
    do_reset();
    b = wr_total;
    enable = 1'b1;
    for (int i = 0; i < 5000 && wr_total - b < 3; i++) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1 && busy == 0 && done == 0, "R9 abort on reset", {spi_cs_n, busy, done}, 3'b100);
    rst_n = 1'b1;
    b = wr_total;
    wait_done();
    verify("R9 restart", b);

    // enable drop mid copy: R10
    enable = 1'b0;
    fill(2);
    do_reset();
    b = wr_total;
    enable = 1'b1;
    for (int i = 0; i < 5000 && wr_total - b < 2; i++) @(negedge clk);
    enable = 1'b0;
    wait_done();
    verify("R10 enable dropped", b);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 10);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule